// File: doc/BRIEF.md
# Dual-Hit Row Scanner

This block walks through one row of pixel hit flags and reports which channels are set, up to two per clock cycle. A row arrives as a flag vector with one bit per channel, together with one data word per channel. Each reported channel comes out on one of two output ports, along with its data word, so a downstream stage can take two readouts per cycle. The scanner can optionally widen every hit to its immediate left and right neighbours before it scans. Pixels next to a hit are then read out even when they stayed below threshold.

The scanner needs no trigger. It takes a row as soon as the row source offers one and it is idle. It works through the row, lowest channel first. When the row holds nothing more, it raises a one-cycle done pulse. The source treats that pulse as the pop of its row buffer and offers the next row after it. Each output port has a valid/ready handshake. The scan pauses while a valid port is not ready, and no channel is lost.

Top module: `row_hit_scanner`

## Requirements
- R1: While the synchronous active-low reset is applied, both port valids and the done pulse are low after the first clock edge.
- R2: Channels are reported in ascending order. In any cycle, port 0 carries the lowest remaining channel and port 1 the next higher one.
- R3: Port 1 is valid only together with port 0, and it is low when a single channel remains in the row.
- R4: Each valid port carries the data word of its channel. Channel k's word occupies bits [k*DW +: DW] of the row data input.
- R5: A row is taken with the neighbour enable sampled at that moment. When that enable is 1, channels k-1 and k+1 of every hit k are also reported, and each channel is still reported once.
- R6: Neighbour widening does not wrap. A hit at channel 0 adds only channel 1, and a hit at the top channel adds only the one below it.
- R7: The done pulse lasts exactly one cycle. It is high in the cycle in which the last remaining channels are accepted, and never in a cycle that is stalled.
- R8: A row with no flagged channel (after widening) gives a done pulse in the first cycle after it is taken, and no port is valid for it.
- R9: While a valid port has its ready low, the scan holds. Valids, indices and data stay unchanged, and the done pulse stays low.
- R10: An idle scanner takes an offered row at the next clock edge, and the first channels of that row are valid in the following cycle.
- R11: Every flagged channel of a row is reported exactly once before that row's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid | input | 1 | A row is offered; it must stay unchanged until the done pulse |
| nbr_en | input | 1 | Neighbour widening for the offered row |
| row_hits | input | NCH | One flag per channel |
| row_data | input | NCH*DW | Per-channel data words, channel k at bits [k*DW +: DW] |
| p0_valid | output | 1 | Port 0 carries a channel |
| p0_ready | input | 1 | Port 0 consumer accepts |
| p0_idx | output | $clog2(NCH) | Port 0 channel index |
| p0_data | output | DW | Port 0 channel data word |
| p1_valid | output | 1 | Port 1 carries a channel |
| p1_ready | input | 1 | Port 1 consumer accepts |
| p1_idx | output | $clog2(NCH) | Port 1 channel index |
| p1_data | output | DW | Port 1 channel data word |
| row_done | output | 1 | Current row finished; pop the row source |

## Verification
The assertions check the per-cycle rules on every clock cycle:
- port 1 never valid without port 0;
- port 1 always above port 0;
- the next pair always above the pair just accepted;
- data matching the selected channel;
- outputs held during a stall;
- done being a single, unstalled pulse;
- quiet outputs under reset.

Only the bench's scenarios can show the rest, because those depend on the content of the row. That covers the exact set of channels reported, so that none is missed or repeated. It also covers widening with clipping at both row edges, the empty row finishing in one cycle, and the latency from an offered row to its first output.

// File: rtl/rhs_pkg.sv
// Package: shared types for the dual-hit row scanner.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rhs_pkg;
    // Scanner control state: waiting for a row, or working through one.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;
endpackage

// File: rtl/rhs_expand.sv
// Module: rhs_expand
// Widens each flagged channel to its direct left and right neighbours when
// enabled. Assumes NCH >= 2. The two edge channels have only one neighbour
// each, so nothing wraps around the row.
module rhs_expand #(
    parameter int NCH = 128
) (
    input  logic           nbr_en,
    input  logic [NCH-1:0] hits,
    output logic [NCH-1:0] marked
);
    // One mark per channel: own flag, or a flagged neighbour when enabled.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_low_edge
            assign marked[g] = hits[g] | (nbr_en & hits[g+1]);
        end else if (g == NCH-1) begin : g_high_edge
            assign marked[g] = hits[g] | (nbr_en & hits[g-1]);
        end else begin : g_mid
            assign marked[g] = hits[g] | (nbr_en & (hits[g-1] | hits[g+1]));
        end
    end
endmodule

// File: rtl/rhs_find2.sv
// Module: rhs_find2
// Finds the lowest and the second-lowest set bits of a vector and encodes
// their positions. It also returns a mask of both bits so the caller can
// clear them. Purely combinational. Assumes NCH is a power of two or that
// its indices fit in $clog2(NCH) bits.
module rhs_find2 #(
    parameter int NCH = 128,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] vec,
    output logic           first_ok,
    output logic [IW-1:0]  first_idx,
    output logic           second_ok,
    output logic [IW-1:0]  second_idx,
    output logic [NCH-1:0] taken
);
    logic [NCH-1:0] iso0;
    logic [NCH-1:0] rest;
    logic [NCH-1:0] iso1;

    // Isolate the lowest set bit, strip it, then isolate the next one.
    assign iso0 = vec & (~vec + NCH'(1));
    assign rest = vec & ~iso0;
    assign iso1 = rest & (~rest + NCH'(1));

    assign first_ok  = |vec;
    assign second_ok = |rest;
    assign taken     = iso0 | iso1;

    // Encode the one-hot isolated bits into channel indices.
    always_comb begin
        first_idx  = '0;
        second_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (iso0[i]) first_idx  = IW'(i);
            if (iso1[i]) second_idx = IW'(i);
        end
    end
endmodule

// File: rtl/rhs_datamux.sv
// Module: rhs_datamux
// Selects one channel's data word from the flattened row data by index.
// Assumes the index is below NCH; channel k lives at bits [k*DW +: DW].
module rhs_datamux #(
    parameter int NCH = 128,
    parameter int DW  = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH*DW-1:0] row_data,
    input  logic [IW-1:0]     sel,
    output logic [DW-1:0]     word
);
    // Indexed part-select of the chosen channel's word.
    assign word = row_data[int'(sel)*DW +: DW];
endmodule

// File: rtl/row_hit_scanner.sv
// Module: row_hit_scanner (top)
// Self-triggered scanner. It loads a row's flag vector, optionally widened
// to neighbours, into a working copy. It reports up to two channels per
// cycle in ascending order on two valid/ready ports, and clears them from
// the copy once both valid ports accept. row_done pulses in the cycle the
// last channels are accepted, or in the first scan cycle of an empty row.
// Assumes the row source keeps row_valid, row_hits, row_data and nbr_en
// stable from the offer until row_done, and treats row_done as its pop.
module row_hit_scanner #(
    parameter int NCH = 128,
    parameter int DW  = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic              nbr_en,
    input  logic [NCH-1:0]    row_hits,
    input  logic [NCH*DW-1:0] row_data,
    output logic              p0_valid,
    input  logic              p0_ready,
    output logic [IW-1:0]     p0_idx,
    output logic [DW-1:0]     p0_data,
    output logic              p1_valid,
    input  logic              p1_ready,
    output logic [IW-1:0]     p1_idx,
    output logic [DW-1:0]     p1_data,
    output logic              row_done
);
    import rhs_pkg::*;

    scan_state_t    state_q;
    logic [NCH-1:0] work_q;
    logic [NCH-1:0] marked;
    logic [NCH-1:0] taken;
    logic [NCH-1:0] remaining;
    logic           f0_ok, f1_ok;
    logic           scanning, stall, step;

    rhs_expand #(.NCH(NCH)) u_expand (
        .nbr_en (nbr_en),
        .hits   (row_hits),
        .marked (marked)
    );

    rhs_find2 #(.NCH(NCH)) u_find (
        .vec        (work_q),
        .first_ok   (f0_ok),
        .first_idx  (p0_idx),
        .second_ok  (f1_ok),
        .second_idx (p1_idx),
        .taken      (taken)
    );

    rhs_datamux #(.NCH(NCH), .DW(DW)) u_mux0 (
        .row_data (row_data),
        .sel      (p0_idx),
        .word     (p0_data)
    );

    rhs_datamux #(.NCH(NCH), .DW(DW)) u_mux1 (
        .row_data (row_data),
        .sel      (p1_idx),
        .word     (p1_data)
    );

    // Step control: advance only when every valid port is accepted.
    always_comb begin
        scanning  = (state_q == ST_SCAN);
        p0_valid  = scanning & f0_ok;
        p1_valid  = scanning & f1_ok;
        stall     = (p0_valid & ~p0_ready) | (p1_valid & ~p1_ready);
        step      = scanning & ~stall;
        remaining = work_q & ~taken;
        row_done  = step & ~(|remaining);
    end

    // State and working copy: load on offer, clear accepted bits on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            work_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (row_valid) begin
                state_q <= ST_SCAN;
                work_q  <= marked;
            end
        end else if (step) begin
            work_q <= remaining;
            if (~(|remaining)) state_q <= ST_IDLE;
        end
    end
endmodule

// File: rtl/rhs_checker.sv
// Module: rhs_checker
// Port-level protocol checks for row_hit_scanner, attached by bind below.
// Assumes the row source holds row_data stable while a row is in work.
module rhs_checker #(
    parameter int NCH = 128,
    parameter int DW  = 8,
    localparam int IW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*DW-1:0] row_data,
    input logic              p0_valid,
    input logic              p0_ready,
    input logic [IW-1:0]     p0_idx,
    input logic [DW-1:0]     p0_data,
    input logic              p1_valid,
    input logic              p1_ready,
    input logic [IW-1:0]     p1_idx,
    input logic [DW-1:0]     p1_data,
    input logic              row_done
);
    logic stalled;

    // A valid port whose consumer is not ready holds the scan.
    assign stalled = (p0_valid & ~p0_ready) | (p1_valid & ~p1_ready);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!p0_valid && !p1_valid && !row_done));

    p_pair_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        p1_valid |-> (p1_idx > p0_idx));

    p_next_pair_higher_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_valid && !stalled && !row_done) |=>
        (p0_valid && (p0_idx > $past(p1_valid ? p1_idx : p0_idx))));

    p_p1_with_p0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        p1_valid |-> p0_valid);

    p_data_p0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p0_valid |-> (p0_data == row_data[int'(p0_idx)*DW +: DW]));

    p_data_p1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        p1_valid |-> (p1_data == row_data[int'(p1_idx)*DW +: DW]));

    p_done_unstalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> !stalled);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> (p0_valid && $stable(p0_idx) && $stable(p1_valid)
                     && (!p1_valid || $stable(p1_idx))));
endmodule

bind row_hit_scanner rhs_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_data (row_data),
    .p0_valid (p0_valid),
    .p0_ready (p0_ready),
    .p0_idx   (p0_idx),
    .p0_data  (p0_data),
    .p1_valid (p1_valid),
    .p1_ready (p1_ready),
    .p1_idx   (p1_idx),
    .p1_data  (p1_data),
    .row_done (row_done)
);

// File: tb/sim_row_hit_scanner.sv
// Bench: behavioural reference (queues) compared with the scanner every cycle.
module sim_row_hit_scanner;
    localparam int NCH = 128;
    localparam int DW  = 8;
    localparam int IW  = $clog2(NCH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              row_valid = 1'b0;
    logic              nbr_en = 1'b0;
    logic [NCH-1:0]    row_hits = '0;
    logic [NCH*DW-1:0] row_data = '0;
    logic              p0_valid, p1_valid, row_done;
    logic              p0_ready = 1'b1, p1_ready = 1'b1;
    logic [IW-1:0]     p0_idx, p1_idx;
    logic [DW-1:0]     p0_data, p1_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Row source: pending rows with their widening, seed, ready mode and tag.
    logic [NCH-1:0] src_hits[$];
    bit             src_nbr[$];
    int             src_seed[$];
    int             src_mode[$];
    string          src_tag[$];

    // Reference state.
    bit    m_busy = 0;
    bit    m_first = 0;
    int    q[$];
    int    m_seed = 0;
    int    m_total = 0;
    int    m_seen = 0;
    string m_tag = "R2";

    always #2 clk = ~clk;

    row_hit_scanner #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .nbr_en(nbr_en),
        .row_hits(row_hits), .row_data(row_data),
        .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_idx(p0_idx), .p0_data(p0_data),
        .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_idx(p1_idx), .p1_data(p1_data),
        .row_done(row_done)
    );

    function automatic logic [DW-1:0] word_of(int ch, int seed);
        return DW'((ch * 37 + seed * 11) ^ (seed >> 1));
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic add_row(logic [NCH-1:0] h, bit nbr, int mode, string tag);
        src_hits.push_back(h);
        src_nbr.push_back(nbr);
        src_seed.push_back(src_seed.size() + 3 * checks + 17);
        src_mode.push_back(mode);
        src_tag.push_back(tag);
    endtask

    // One cycle: drive inputs at the falling edge, compare, advance the model.
    task automatic cycle();
        int  mode;
        bit  e0, e1, stall, step, edone;
        string vtag;
        @(negedge clk);
        mode = (src_mode.size() > 0) ? src_mode[0] : 0;
        case (mode)
            0: begin p0_ready = 1'b1; p1_ready = 1'b1; end
            1: begin p0_ready = ($urandom % 2) == 0; p1_ready = ($urandom % 2) == 0; end
            default: begin p0_ready = ($urandom % 4) != 0; p1_ready = ($urandom % 3) == 0; end
        endcase
        if (src_hits.size() > 0) begin
            row_valid = 1'b1;
            row_hits  = src_hits[0];
            nbr_en    = src_nbr[0];
            for (int i = 0; i < NCH; i++) row_data[i*DW +: DW] = word_of(i, src_seed[0]);
        end else begin
            row_valid = 1'b0;
            row_hits  = '0;
            nbr_en    = 1'b0;
        end
        #1;
        e0 = m_busy && q.size() > 0;
        e1 = m_busy && q.size() > 1;
        stall = (e0 && !p0_ready) || (e1 && !p1_ready);
        step  = m_busy && !stall;
        edone = step && q.size() <= 2;
        vtag  = m_first ? "R10" : (stall ? "R9" : "R3");
        check(p0_valid == e0, {vtag, " p0_valid"}, p0_valid, e0);
        check(p1_valid == e1, {vtag, " p1_valid"}, p1_valid, e1);
        check(row_done == edone, (m_busy && m_total == 0) ? "R8 row_done" :
              (stall ? "R9 row_done" : "R7 row_done"), row_done, edone);
        if (e0 && p0_valid) begin
            check(p0_idx == IW'(q[0]), {m_tag, " p0_idx"}, p0_idx, q[0]);
            check(p0_data == word_of(q[0], m_seed), "R4 p0_data", p0_data, word_of(q[0], m_seed));
        end
        if (e1 && p1_valid) begin
            check(p1_idx == IW'(q[1]), {m_tag, " p1_idx"}, p1_idx, q[1]);
            check(p1_data == word_of(q[1], m_seed), "R4 p1_data", p1_data, word_of(q[1], m_seed));
        end
        if (step) m_seen += int'(p0_valid) + int'(p1_valid);
        // Model advance for the coming rising edge.
        if (!m_busy) begin
            m_first = 0;
            if (row_valid) begin
                q.delete();
                for (int i = 0; i < NCH; i++) begin
                    bit lft, rgt;
                    lft = (i > 0) && row_hits[(i > 0) ? i-1 : 0];
                    rgt = (i < NCH-1) && row_hits[(i < NCH-1) ? i+1 : 0];
                    if (row_hits[i] || (nbr_en && (lft || rgt))) q.push_back(i);
                end
                m_busy  = 1;
                m_first = 1;
                m_seed  = src_seed[0];
                m_tag   = src_tag[0];
                m_total = q.size();
                m_seen  = 0;
            end
        end else begin
            m_first = m_first && stall;
            if (step) begin
                if (q.size() > 0) void'(q.pop_front());
                if (q.size() > 0 && e1) void'(q.pop_front());
            end
            if (edone) begin
                check(m_seen == m_total, "R11 reported count", m_seen, m_total);
                m_busy = 0;
                void'(src_hits.pop_front());
                void'(src_nbr.pop_front());
                void'(src_seed.pop_front());
                void'(src_mode.pop_front());
                void'(src_tag.pop_front());
            end
        end
    endtask

    initial begin
        logic [NCH-1:0] h;
        // R1: reset quiets all outputs.
        repeat (2) @(negedge clk);
        check(!p0_valid && !p1_valid && !row_done, "R1 outputs in reset",
              int'(p0_valid) + int'(p1_valid) + int'(row_done), 0);
        @(negedge clk);
        rst_n = 1'b1;

        add_row('0, 0, 0, "R8");
        add_row(NCH'(1), 0, 0, "R2");
        add_row(NCH'(1) << (NCH-1), 0, 1, "R2");
        h = '0; h[5] = 1; h[9] = 1; add_row(h, 0, 0, "R2");
        h = '0; h[3] = 1; h[4] = 1; h[100] = 1; add_row(h, 0, 2, "R2");
        add_row('1, 0, 0, "R11");
        add_row({(NCH/2){2'b01}}, 0, 1, "R11");
        h = '0; h[0] = 1; h[NCH-1] = 1; add_row(h, 1, 0, "R6");
        h = '0; h[10] = 1; h[12] = 1; add_row(h, 1, 2, "R5");
        h = '0; h[64] = 1; add_row(h, 1, 0, "R5");
        h = '0; h[64] = 1; add_row(h, 0, 0, "R5");
        add_row('0, 1, 1, "R8");
        for (int r = 0; r < 24; r++) begin
            int occ;
            occ = 2 + (r * 7) % 40;
            h = '0;
            for (int i = 0; i < NCH; i++) h[i] = ($urandom % 100) < occ;
            add_row(h, r % 2 == 1, r % 3, (r % 2 == 1) ? "R5" : "R2");
        end

        while (src_hits.size() > 0 || m_busy) cycle();
        repeat (3) cycle();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule